// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the serial clock for an I2C master, one byte at a time. A control byte selects a 5-bit divisor, a rate mode, whether a ninth acknowledge clock follows the eight data clocks, and what level the master puts on SDA during that ninth clock. A byte shifter outside this block pulses `xfer_start` to request one byte. It says with `xfer_rx` whether the master is receiving the byte. When the last clock pulse of the byte has finished, this block returns a one-cycle `byte_done`.

Each clock pulse is a low phase followed by a high phase. The lengths of both phases are counted in system-clock cycles and derived from the divisor. In standard mode each phase lasts four times the divisor. In fast mode each phase lasts twice the divisor, except for divisor 5, which gives a 6-cycle low phase and a 4-cycle high phase. Low divisor codes are rejected. SCL and SDA are open-drain: an output enable of 1 pulls the line low. A write to the control byte always takes effect, and if a byte is in flight it is cut short.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset the control byte is 0 (divisor 0, standard mode, no acknowledge clock, ACK level 0). `busy`, `scl_oe`, `sda_oe` and `byte_done` are 0, and a start request made with this reset setting produces no clock.
- R2: Control byte layout: bits 4:0 divisor, bit 5 fast mode, bit 6 ACK level, bit 7 acknowledge-clock enable. Divisors 0 to 3 in standard mode and 0 to 2 in fast mode are invalid. With an invalid divisor a start request is ignored: `busy` stays 0 and SCL stays released.
- R3: In standard mode each low phase and each high phase lasts 4 × divisor system cycles.
- R4: In fast mode each low phase and each high phase lasts 2 × divisor system cycles, for every valid divisor other than 5.
- R5: In fast mode with divisor 5, every low phase lasts 6 cycles and every high phase lasts 4 cycles.
- R6: With the acknowledge clock disabled, a byte consists of exactly 8 low/high pulses. `byte_done` is high for one cycle, in the first cycle after the last high phase, when `busy` has just dropped.
- R7: With the acknowledge clock enabled, a byte consists of exactly 9 pulses, all with the same phase lengths.
- R8: When the master is receiving (`xfer_rx`=1 at start) with ACK level 0, `sda_oe` is 1 for the whole ninth pulse (both phases) and 0 during the eight data pulses.
- R9: With ACK level 1, or when the master is transmitting, `sda_oe` stays 0 for the whole byte.
- R10: When the master is transmitting with the acknowledge clock enabled, `ack_sampled` takes the value of `sda_in` at the rising SCL edge of the ninth pulse and holds it after the byte ends.
- R11: A control write while `busy` is 1 stops the byte. From the next cycle `busy` and `scl_oe` are 0, and no `byte_done` is produced for the stopped byte.
- R12: Whenever `busy` is 0, SCL is released (`scl_oe`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| xfer_start | input | 1 | Request one byte of clock pulses |
| xfer_rx | input | 1 | 1 = master receives this byte and drives the acknowledge |
| sda_in | input | 1 | Sampled SDA line |
| busy | output | 1 | A byte is being clocked |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge drive) |
| byte_done | output | 1 | One-cycle pulse at the end of a byte |
| ack_sampled | output | 1 | SDA level latched at the ninth rising edge |

## Verification
The assertions check the following on every cycle:
- SCL is never pulled low while the block is idle.
- SDA is only pulled low during a byte and never when the ACK level is 1.
- `byte_done` is a single pulse that coincides with the drop of `busy`.
- A control write during a byte clears `busy` on the next cycle without a done pulse.
- A start request with an invalid divisor never makes the block busy.

Only the bench scenarios can show:
- the exact phase lengths for each divisor and mode, including the uneven 6/4 case;
- the pulse count with and without the acknowledge clock;
- that the SDA drive covers exactly the ninth pulse;
- which SDA value ends up latched as the acknowledge.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int DIV_W = 5;
    localparam int CNT_W = 8;
    localparam int CFG_W = DIV_W + 3;

    typedef struct packed {
        logic             ack_clk_en;
        logic             ack_level;
        logic             fast;
        logic [DIV_W-1:0] div;
    } scl_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_t;

    typedef struct packed {
        logic [CNT_W-1:0] low_len;
        logic [CNT_W-1:0] high_len;
        logic             valid;
    } scl_timing_t;

    function automatic scl_timing_t decode_timing(
        input scl_cfg_t c,
        input int       std_mult,
        input int       fast_mult,
        input int       std_min,
        input int       fast_min,
        input int       odd_code,
        input int       odd_low,
        input int       odd_high
    );
        scl_timing_t t;
        int d;
        int lo;
        int hi;
        d = int'(c.div);
        if (c.fast && d == odd_code) begin
            lo = odd_low;
            hi = odd_high;
        end else if (c.fast) begin
            lo = d * fast_mult;
            hi = lo;
        end else begin
            lo = d * std_mult;
            hi = lo;
        end
        t.low_len  = CNT_W'(lo);
        t.high_len = CNT_W'(hi);
        t.valid    = c.fast ? (d >= fast_min) : (d >= std_min);
        return t;
    endfunction

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
    import scl_gen_pkg::*;
#(
    parameter int STD_MULT  = 4,
    parameter int FAST_MULT = 2,
    parameter int STD_MIN   = 4,
    parameter int FAST_MIN  = 3,
    parameter int ODD_CODE  = 5,
    parameter int ODD_LOW   = 6,
    parameter int ODD_HIGH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic             ack_clk_en,
    output logic             ack_level,
    output scl_timing_t      tim
);

    scl_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= scl_cfg_t'(wdata);
        end
    end

    always_comb begin
        tim        = decode_timing(cfg_q, STD_MULT, FAST_MULT, STD_MIN, FAST_MIN,
                                   ODD_CODE, ODD_LOW, ODD_HIGH);
        ack_clk_en = cfg_q.ack_clk_en;
        ack_level  = cfg_q.ack_level;
    end

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // A load of N keeps "last" low for N-1 cycles, so the phase spans N cycles.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/scl_bit_seq.sv
module scl_bit_seq
    import scl_gen_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  logic             rx,
    input  logic             ack_clk_en,
    input  logic             ack_level,
    input  scl_timing_t      tim,
    input  logic             last,
    input  logic             sda_in,
    output logic             load,
    output logic [CNT_W-1:0] load_len,
    output logic             busy,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             byte_done,
    output logic             ack_sampled
);

    localparam int IDX_W = $clog2(NBITS + 2);
    localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(NBITS);
    localparam logic [IDX_W-1:0] DATA_END = IDX_W'(NBITS - 1);

    scl_phase_t       phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             rx_q;
    logic             ackclk_q;
    logic             acklvl_q;
    logic [IDX_W-1:0] final_idx;

    assign final_idx = ackclk_q ? ACK_IDX : DATA_END;

    always_comb begin
        load     = 1'b0;
        load_len = tim.low_len;
        unique case (phase_q)
            PH_IDLE: load = start && tim.valid;
            PH_LOW: begin
                load     = last;
                load_len = tim.high_len;
            end
            PH_HIGH: load = last && (idx_q != final_idx);
            default: load = 1'b0;
        endcase
        if (abort) begin
            load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            idx_q       <= '0;
            rx_q        <= 1'b0;
            ackclk_q    <= 1'b0;
            acklvl_q    <= 1'b0;
            byte_done   <= 1'b0;
            ack_sampled <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (abort) begin
                phase_q <= PH_IDLE;
                idx_q   <= '0;
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        if (start && tim.valid) begin
                            phase_q  <= PH_LOW;
                            idx_q    <= '0;
                            rx_q     <= rx;
                            ackclk_q <= ack_clk_en;
                            acklvl_q <= ack_level;
                        end
                    end
                    PH_LOW: begin
                        if (last) begin
                            phase_q <= PH_HIGH;
                            if (idx_q == ACK_IDX && !rx_q) begin
                                ack_sampled <= sda_in;
                            end
                        end
                    end
                    PH_HIGH: begin
                        if (last) begin
                            if (idx_q == final_idx) begin
                                phase_q   <= PH_IDLE;
                                idx_q     <= '0;
                                byte_done <= 1'b1;
                            end else begin
                                phase_q <= PH_LOW;
                                idx_q   <= idx_q + IDX_W'(1);
                            end
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign busy   = (phase_q != PH_IDLE);
    assign scl_oe = (phase_q == PH_LOW);
    assign sda_oe = busy && (idx_q == ACK_IDX) && rx_q && !acklvl_q;

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import scl_gen_pkg::*;
#(
    parameter int NBITS     = 8,
    parameter int STD_MULT  = 4,
    parameter int FAST_MULT = 2,
    parameter int STD_MIN   = 4,
    parameter int FAST_MIN  = 3,
    parameter int ODD_CODE  = 5,
    parameter int ODD_LOW   = 6,
    parameter int ODD_HIGH  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       xfer_start,
    input  logic       xfer_rx,
    input  logic       sda_in,
    output logic       busy,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       byte_done,
    output logic       ack_sampled
);

    scl_timing_t      tim_q;
    logic             cfg_ack_clk_en;
    logic             cfg_ack_level;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;

    scl_cfg_reg #(
        .STD_MULT (STD_MULT),
        .FAST_MULT(FAST_MULT),
        .STD_MIN  (STD_MIN),
        .FAST_MIN (FAST_MIN),
        .ODD_CODE (ODD_CODE),
        .ODD_LOW  (ODD_LOW),
        .ODD_HIGH (ODD_HIGH)
    ) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .ack_clk_en(cfg_ack_clk_en),
        .ack_level (cfg_ack_level),
        .tim       (tim_q)
    );

    scl_phase_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk (clk),
        .rst (rst),
        .clr (cfg_we),
        .load(tmr_load),
        .len (tmr_len),
        .last(tmr_last)
    );

    scl_bit_seq #(.NBITS(NBITS)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .abort      (cfg_we),
        .start      (xfer_start),
        .rx         (xfer_rx),
        .ack_clk_en (cfg_ack_clk_en),
        .ack_level  (cfg_ack_level),
        .tim        (tim_q),
        .last       (tmr_last),
        .sda_in     (sda_in),
        .load       (tmr_load),
        .load_len   (tmr_len),
        .busy       (busy),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .byte_done  (byte_done),
        .ack_sampled(ack_sampled)
    );

endmodule

// File: rtl/scl_gen_checker.sv
module scl_gen_checker (
    input logic clk,
    input logic rst,
    input logic cfg_we,
    input logic busy,
    input logic scl_oe,
    input logic sda_oe,
    input logic byte_done,
    input logic ack_level,
    input logic cfg_valid
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !byte_done && !scl_oe));

    p_invalid_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_valid && !busy) |=> !busy);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !byte_done);

    p_done_at_exit_r6: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> (!busy && $past(busy)));

    p_sda_in_byte_r8: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> busy);

    p_nack_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> !ack_level);

    p_abort_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && busy) |=> (!busy && !byte_done));

    p_idle_released_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !scl_oe);

endmodule

bind i2c_scl_gen scl_gen_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .busy     (busy),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .byte_done(byte_done),
    .ack_level(cfg_ack_level),
    .cfg_valid(tim_q.valid)
);

// File: tb/i2c_scl_gen_tb_top.sv
module i2c_scl_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       xfer_start = 1'b0;
    logic       xfer_rx = 1'b0;
    logic       sda_in = 1'b1;
    logic       busy;
    logic       scl_oe;
    logic       sda_oe;
    logic       byte_done;
    logic       ack_sampled;

    always #4 clk = ~clk;

    i2c_scl_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .xfer_start (xfer_start),
        .xfer_rx    (xfer_rx),
        .sda_in     (sda_in),
        .busy       (busy),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .byte_done  (byte_done),
        .ack_sampled(ack_sampled)
    );

    typedef struct {
        bit    low;
        int    len;
        bit    sda;
        string req;
    } seg_t;

    seg_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   done_cnt = 0;
    int   busy_rises = 0;
    int   idle_drive = 0;
    bit   sb_en = 1'b1;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: splits the busy period into SCL phases and scores them.
    logic [1:0] prev_key = 2'b00;
    int  run_len = 0;
    bit  run_sda_any = 1'b0;
    bit  run_sda_all = 1'b1;
    bit  prev_busy = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if ({busy, scl_oe} != prev_key) begin
                if (prev_key[1] && sb_en) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 extra phase", run_len, 0);
                    end else begin
                        seg_t e;
                        e = exp_q.pop_front();
                        check(e.low == prev_key[0], e.req, int'(prev_key[0]), int'(e.low));
                        check(e.len == run_len, e.req, run_len, e.len);
                        check((run_sda_any == e.sda) && (run_sda_all == e.sda),
                              e.sda ? "R8 sda drive" : "R9 sda quiet",
                              int'(run_sda_any), int'(e.sda));
                    end
                end
                run_len = 0;
                run_sda_any = 1'b0;
                run_sda_all = 1'b1;
            end
            prev_key = {busy, scl_oe};
            run_len++;
            run_sda_any = run_sda_any | sda_oe;
            run_sda_all = run_sda_all & sda_oe;
            if (byte_done) done_cnt++;
            if (busy && !prev_busy) busy_rises++;
            if (!busy && scl_oe) idle_drive++;
            prev_busy = busy;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        tick();
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start(input bit rx);
        tick();
        xfer_start = 1'b1;
        xfer_rx = rx;
        tick();
        xfer_start = 1'b0;
    endtask

    function automatic bit code_ok(input logic [7:0] c);
        return c[5] ? (c[4:0] >= 5'd3) : (c[4:0] >= 5'd4);
    endfunction

    // Driver: pushes the expected phase list for one byte, then runs it.
    task automatic run_byte(input logic [7:0] c, input bit rx, input bit sda_v, input string req);
        int lo;
        int hi;
        int npulse;
        int d0;
        lo = c[5] ? ((c[4:0] == 5'd5) ? 6 : 2 * int'(c[4:0])) : 4 * int'(c[4:0]);
        hi = c[5] ? ((c[4:0] == 5'd5) ? 4 : 2 * int'(c[4:0])) : 4 * int'(c[4:0]);
        npulse = c[7] ? 9 : 8;
        write_cfg(c);
        sda_in = sda_v;
        for (int k = 0; k < npulse; k++) begin
            bit s;
            s = (k == 8) && rx && !c[6];
            exp_q.push_back('{1'b1, lo, s, req});
            exp_q.push_back('{1'b0, hi, s, req});
        end
        d0 = done_cnt;
        pulse_start(rx);
        for (int w = 0; w < 6000 && done_cnt == d0; w++) tick();
        tick();
        tick();
        check(exp_q.size() == 0, c[7] ? "R7 pulse count" : "R6 pulse count", exp_q.size(), 0);
        check(done_cnt == d0 + 1, "R6 one done pulse", done_cnt - d0, 1);
        if (!rx && c[7]) begin
            check(ack_sampled == sda_v, "R10 ack sample", int'(ack_sampled), int'(sda_v));
        end
        exp_q.delete();
    endtask

    task automatic try_invalid(input logic [7:0] c, input string req);
        int b0;
        write_cfg(c);
        b0 = busy_rises;
        pulse_start(1'b0);
        repeat (60) tick();
        check(busy_rises == b0, req, busy_rises - b0, 0);
        check(scl_oe == 1'b0, req, int'(scl_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        tick();
        // R1: reset state at the ports
        check(busy == 1'b0 && byte_done == 1'b0, "R1 reset busy/done", int'(busy), 0);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 reset lines", int'(scl_oe), 0);
        begin
            int b0;
            b0 = busy_rises;
            pulse_start(1'b0);
            repeat (40) tick();
            check(busy_rises == b0, "R1 reset divisor rejects start", busy_rises - b0, 0);
        end

        // R2: invalid codes
        try_invalid(8'h03, "R2 std code 3");
        try_invalid(8'h00, "R2 std code 0");
        try_invalid(8'h22, "R2 fast code 2");
        try_invalid(8'h21, "R2 fast code 1");

        // R3: standard timing
        run_byte(8'h04, 1'b0, 1'b1, "R3 std div 4");
        run_byte(8'h06, 1'b0, 1'b1, "R3 std div 6");
        run_byte(8'h1F, 1'b0, 1'b1, "R3 std div 31");

        // R4: fast timing
        run_byte(8'h23, 1'b0, 1'b1, "R4 fast div 3");
        run_byte(8'h24, 1'b0, 1'b1, "R4 fast div 4");
        run_byte(8'h3F, 1'b0, 1'b1, "R4 fast div 31");

        // R5: uneven duty case
        run_byte(8'h25, 1'b0, 1'b1, "R5 fast div 5");
        run_byte(8'hA5, 1'b1, 1'b1, "R5 fast div 5 ack");

        // R7/R8: receive with ack drive
        run_byte(8'h86, 1'b1, 1'b1, "R8 rx ack low");
        // R9: nack level and transmit side
        run_byte(8'hC6, 1'b1, 1'b1, "R9 rx nack");
        // R10: transmit samples receiver ack
        run_byte(8'hA7, 1'b0, 1'b0, "R10 tx ack 0");
        run_byte(8'hA7, 1'b0, 1'b1, "R10 tx ack 1");
        run_byte(8'hC4, 1'b0, 1'b0, "R9 tx nack level");

        // R11: write during a byte aborts it
        begin
            int d0;
            write_cfg(8'h06);
            sb_en = 1'b0;
            d0 = done_cnt;
            pulse_start(1'b0);
            repeat (30) tick();
            check(busy == 1'b1, "R11 byte running", int'(busy), 1);
            write_cfg(8'h06);
            check(busy == 1'b0 && scl_oe == 1'b0, "R11 abort stops clock", int'(busy), 0);
            repeat (300) tick();
            check(done_cnt == d0, "R11 no done after abort", done_cnt - d0, 0);
            sb_en = 1'b1;
            run_byte(8'h07, 1'b0, 1'b1, "R11 clean byte after abort");
        end

        // R12: idle release observed throughout
        check(idle_drive == 0, "R12 idle release", idle_drive, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule